// File: doc/BRIEF.md
# Logic Self-Test Signature Engine

This block runs a built-in self-test of logic that already has scan chains. A pattern generator drives a parallel set of scan-chain inputs. It is a Galois LFSR with a programmable feedback mask, and the mask chosen by default gives a maximal-length 32-bit sequence. A multiple-input signature register (MISR) folds the parallel scan-chain outputs into one running signature. A small controller orders the run: seed, then a programmed number of shift cycles, then a compare of the signature against a known-good value, then the report.

A run begins with a one-cycle pulse on the start input. That pulse can come from a power-on startup sequencer or from a watchdog. The result appears on the done, pass and fail outputs and in a four-bit status word. It stays there until the next start. An optional one-cycle interrupt marks the end of each run.

Top module: `lbist_engine`

## Requirements
- R1: After reset, done_o, pass_o, fail_o and irq_o are 0 and status_o is 4'b0000.
- R2: The rising edge that samples start_i high while idle makes the engine busy. One seed cycle follows, then N run cycles, then one compare cycle. done_o rises after the edge N+2 edges after the one that sampled start, and busy drops on that same edge. While busy, done_o, pass_o and fail_o read 0.
- R3: In the seed cycle the pattern register is loaded with the nonzero PRPG_SEED. Every run cycle it advances as next = (s >> 1) XOR (s[0] ? PRPG_POLY : 0). In run cycle k, scan_in_o equals the low CHAINS bits of the seed after k advances.
- R4: In the seed cycle the signature is cleared to zero. Every run cycle it becomes (m << 1) XOR (m[MSB] ? MISR_POLY : 0) XOR zero-extended scan_out_i, so chain i feeds stage i.
- R5: At the compare cycle, pass_o=1 and fail_o=0 if the signature equals golden_i, and pass_o=0 and fail_o=1 otherwise.
- R6: Once done_o is set, done_o, pass_o and fail_o hold their values until a new start is sampled.
- R7: A start pulse sampled while busy is ignored: the run and its length are unaffected.
- R8: A pattern count of 0 runs no shift cycles. The signature compared is then zero, and done_o rises two edges after the start edge.
- R9: With IRQ_EN set, irq_o is high for exactly the one cycle in which done_o first reads 1.
- R10: status_o reads {fail, pass, done, busy} from bit 3 down to bit 0.
- R11: pat_count_i is sampled only with the start pulse. A change during a run does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request pulse (startup or watchdog) |
| pat_count_i | input | CNT_W | Number of shift cycles for the run |
| scan_in_o | output | CHAINS | Pseudo-random bits to the scan-chain inputs |
| scan_out_i | input | CHAINS | Responses from the scan-chain outputs |
| golden_i | input | MISR_W | Known-good signature |
| done_o | output | 1 | Run finished, result valid |
| pass_o | output | 1 | Signature matched |
| fail_o | output | 1 | Signature mismatched |
| irq_o | output | 1 | One-cycle end-of-run interrupt |
| status_o | output | 4 | {fail, pass, done, busy} |

## Verification
The bench targets a zero pattern count, single-cycle runs and a run several hundred cycles long. An engine with a wrong off-by-one count would raise done a cycle early or late, or fold one pattern too few or too many, and the signature would no longer match. The bench also pulses start and changes the count in the middle of a run: an engine that restarted or re-sampled the count would change the latency. It injects a stuck response bit, and an engine that compacted incorrectly or compared sloppily would report pass. Finally it holds the result for many idle cycles, so any drift of done, pass or fail, or a repeated interrupt, shows up.

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter int                PRPG_W    = 32,
  parameter logic [PRPG_W-1:0] PRPG_POLY = 32'h8020_0003,
  parameter logic [PRPG_W-1:0] PRPG_SEED = 32'hACE1_2345,
  parameter int                MISR_W    = 32,
  parameter logic [MISR_W-1:0] MISR_POLY = 32'h04C1_1DB7,
  parameter int                CHAINS    = 8,
  parameter int                CNT_W     = 16,
  parameter bit                IRQ_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  pat_count_i,
  output logic [CHAINS-1:0] scan_in_o,
  input  logic [CHAINS-1:0] scan_out_i,
  input  logic [MISR_W-1:0] golden_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              irq_o,
  output logic [3:0]        status_o
);

  typedef enum logic [1:0] {S_IDLE, S_SEED, S_RUN, S_CMP} st_t;

  st_t               st;
  logic [PRPG_W-1:0] prpg;
  logic [MISR_W-1:0] misr;
  logic [CNT_W-1:0]  cnt;
  logic              busy;

  wire [PRPG_W-1:0] prpg_nx = {1'b0, prpg[PRPG_W-1:1]} ^ (prpg[0] ? PRPG_POLY : '0);
  wire [MISR_W-1:0] misr_nx = {misr[MISR_W-2:0], 1'b0}
                            ^ (misr[MISR_W-1] ? MISR_POLY : '0)
                            ^ MISR_W'(scan_out_i);

  assign busy      = (st != S_IDLE);
  assign scan_in_o = prpg[CHAINS-1:0];
  assign status_o  = {fail_o, pass_o, done_o, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      prpg   <= PRPG_SEED;
      misr   <= '0;
      cnt    <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st     <= S_SEED;
          cnt    <= pat_count_i;
          done_o <= 1'b0;
          pass_o <= 1'b0;
          fail_o <= 1'b0;
        end
        S_SEED: begin
          prpg <= PRPG_SEED;
          misr <= '0;
          st   <= (cnt == '0) ? S_CMP : S_RUN;
        end
        S_RUN: begin
          prpg <= prpg_nx;
          misr <= misr_nx;
          cnt  <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_CMP;
        end
        default: begin
          done_o <= 1'b1;
          pass_o <= (misr == golden_i);
          fail_o <= (misr != golden_i);
          irq_o  <= IRQ_EN;
          st     <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       done_o,
  input logic       pass_o,
  input logic       fail_o,
  input logic       irq_o,
  input logic [3:0] status_o
);

  a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_o)));

  a_r2_busy_clean: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> (!done_o && !pass_o && !fail_o));

  a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $rose(done_o));

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(status_o[0]));

endmodule

bind lbist_engine lbist_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .pass_o(pass_o), .fail_o(fail_o), .irq_o(irq_o), .status_o(status_o)
);

// File: tb/lbist_engine_bench.sv
module lbist_engine_bench;
  localparam logic [31:0] P_POLY = 32'h8020_0003;
  localparam logic [31:0] P_SEED = 32'hACE1_2345;
  localparam logic [31:0] M_POLY = 32'h04C1_1DB7;

  logic        clk = 0, rst_n = 0, start_i = 0;
  logic [15:0] pat_count_i = 0;
  logic [31:0] golden_i = 0;
  logic [7:0]  fault_mask = 0;
  logic [7:0]  scan_in_o, scan_out_i;
  logic        done_o, pass_o, fail_o, irq_o;
  logic [3:0]  status_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  lbist_engine #(.PRPG_W(32), .PRPG_POLY(P_POLY), .PRPG_SEED(P_SEED), .MISR_W(32),
                 .MISR_POLY(M_POLY), .CHAINS(8), .CNT_W(16), .IRQ_EN(1'b1)) u_lbist_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pat_count_i(pat_count_i),
    .scan_in_o(scan_in_o), .scan_out_i(scan_out_i), .golden_i(golden_i),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .irq_o(irq_o), .status_o(status_o));

  always #4 clk = ~clk;

  function automatic logic [7:0] cut(input logic [7:0] si);
    return si ^ {si[0], si[7:1]} ^ 8'h5A;
  endfunction
  function automatic logic [31:0] pstep(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? P_POLY : 32'h0);
  endfunction
  function automatic logic [31:0] mstep(input logic [31:0] m, input logic [7:0] d);
    return (m << 1) ^ (m[31] ? M_POLY : 32'h0) ^ {24'h0, d};
  endfunction
  function automatic logic [31:0] golden_of(input int n);
    logic [31:0] p = P_SEED, m = 0;
    for (int k = 0; k < n; k++) begin
      m = mstep(m, cut(p[7:0]));
      p = pstep(p);
    end
    return m;
  endfunction

  assign scan_out_i = cut(scan_in_o) ^ fault_mask;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  int          m_st = 0, m_cnt = 0;
  logic [31:0] m_p = P_SEED, m_m = 0;
  logic        e_done = 0, e_pass = 0, e_fail = 0, e_irq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_p = P_SEED; m_m = 0;
      e_done = 0; e_pass = 0; e_fail = 0; e_irq = 0;
    end else begin
      e_irq = 0;
      if (m_st == 0) begin
        if (start_i) begin
          m_st = 1; m_cnt = int'(pat_count_i); e_done = 0; e_pass = 0; e_fail = 0;
        end
      end else if (m_st == 1) begin
        m_p = P_SEED; m_m = 0; m_st = (m_cnt == 0) ? 3 : 2;
      end else if (m_st == 2) begin
        m_m = mstep(m_m, cut(m_p[7:0]) ^ fault_mask);
        m_p = pstep(m_p);
        m_cnt--;
        if (m_cnt == 0) m_st = 3;
      end else begin
        e_done = 1; e_pass = (m_m == golden_i); e_fail = !e_pass; e_irq = 1; m_st = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(done_o == e_done, "R2/R6 done", done_o, e_done);
    chk({pass_o, fail_o} == {e_pass, e_fail}, "R5/R6 pass,fail", {pass_o, fail_o}, {e_pass, e_fail});
    chk(irq_o == e_irq, "R9 irq", irq_o, e_irq);
    chk(status_o == {e_fail, e_pass, e_done, m_st != 0}, "R10 status", status_o,
        {e_fail, e_pass, e_done, m_st != 0});
    if (m_st == 2) chk(scan_in_o == m_p[7:0], "R3 scan_in pattern", scan_in_o, m_p[7:0]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(input int n, input logic [31:0] gold, input bit exp_pass,
                     input bit disturb, input string tag);
    int c;
    @(negedge clk);
    pat_count_i = 16'(n); golden_i = gold; start_i = 1;
    @(negedge clk);
    start_i = 0; c = 1;
    if (disturb) begin
      pat_count_i = 16'd999;
      @(negedge clk); c++;
      start_i = 1;            // R7: ignored while busy
      @(negedge clk); c++;
      start_i = 0;
    end
    while (!done_o && c < 100000) begin @(negedge clk); c++; end
    chk(c - 1 == n + 2, {tag, " latency"}, c - 1, n + 2);
    chk(pass_o == exp_pass && fail_o == !exp_pass, {tag, " verdict"}, {pass_o, fail_o}, {exp_pass, !exp_pass});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({done_o, pass_o, fail_o, irq_o} == 4'b0, "R1 reset outputs", {done_o, pass_o, fail_o, irq_o}, 0);
    chk(status_o == 4'b0, "R1 reset status", status_o, 0);
    rst_n = 1;
    @(negedge clk);
    run(5, golden_of(5), 1, 0, "R2 R4 R5 n=5 match");
    run(5, golden_of(5) ^ 32'h1, 0, 0, "R5 n=5 mismatch");
    run(0, 32'h0, 1, 0, "R8 n=0 zero signature");
    run(0, 32'h1, 0, 0, "R8 n=0 nonzero golden");
    run(1, golden_of(1), 1, 0, "R3 R4 n=1");
    run(6, golden_of(6), 1, 1, "R7 R11 start and count change mid-run");
    fault_mask = 8'h04;
    run(20, golden_of(20), 0, 0, "R4 R5 stuck response bit");
    fault_mask = 8'h00;
    run(400, golden_of(400), 1, 0, "R3 R4 n=400");
    repeat (20) @(negedge clk);
    chk(done_o && pass_o && !fail_o, "R6 held after idle", {done_o, pass_o, fail_o}, 3'b110);
    chk(irq_o == 0, "R9 no repeat irq", irq_o, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule